// File: doc/BRIEF.md
# Predicated element issue splitter

This block sits between instruction issue and an ALU that has a configurable number of lanes. It receives one vectorised arithmetic operation: a destination and two source base register numbers, a flag per operand that marks it as vector or scalar, a vector length and a predicate mask with one bit per element. It then splits that operation into scalar element operations. Each cycle it fills the ALU lanes with up to `LANES` elements that are due for issue. Those elements are packed into the lowest lanes, and each lane carries the element number and the three register numbers that element uses.

The block keeps a pending element mask. Each cycle it clears the elements it has just issued, and it stays busy until the mask is empty. A per-operation fill mode chooses between two behaviours for elements whose predicate bit is clear. In skip mode they are dropped. In zeroing mode they are issued with a flag that tells the ALU to write zero to the destination. A new operation is accepted only while the block is idle.

Top module: `elem_issue_split`

## Requirements
- R1: After reset, `in_ready` is 1 and all `lane_valid` bits are 0. An operation is captured only on a clock edge where both `in_valid` and `in_ready` are 1. `in_ready` is 0 in every cycle in which any lane is valid.
- R2: In each cycle, the issued elements occupy lanes 0 upward with no gaps. They are the lowest-numbered pending elements, in ascending element order, up to `LANES` of them.
- R3: Elements issued in a cycle are removed from the pending set. An operation with E elements to issue takes ceil(E/LANES) consecutive cycles, starting in the cycle after acceptance. `in_ready` returns to 1 in the cycle after the last group.
- R4: For element i, a vector operand uses register (base + i) modulo 2^RW, and a scalar operand uses its base register.
- R5: When all three operand flags are 0, exactly one element is issued, with index 0, the three base registers and `lane_zero` 0. VL, the predicate and the fill mode are ignored.
- R6: Predicate bit i (bit 0 = element 0) enables element i. In skip mode (`op_zero`=0), only enabled elements below VL are issued, each with `lane_zero`=0.
- R7: In zeroing mode (`op_zero`=1), every element 0..VL-1 is issued exactly once, in ascending order. `lane_zero` is 1 exactly for elements whose predicate bit is 0.
- R8: Elements with index >= VL are never issued. If VL is 0, or no element below VL is enabled in skip mode, nothing is issued and `in_ready` stays 1.
- R9: `in_valid` while the block is busy has no effect. The operation in progress continues unchanged, and the presented operation is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New operation presented |
| in_ready | output | 1 | Idle; operation accepted on this edge if valid |
| op_rd | input | RW | Destination base register |
| op_rs1 | input | RW | Source 1 base register |
| op_rs2 | input | RW | Source 2 base register |
| op_rd_vec | input | 1 | Destination is a vector |
| op_rs1_vec | input | 1 | Source 1 is a vector |
| op_rs2_vec | input | 1 | Source 2 is a vector |
| op_vl | input | VW | Vector length, 0..XLEN |
| op_pred | input | XLEN | Predicate, bit i for element i |
| op_zero | input | 1 | 1 = zeroing mode, 0 = skip mode |
| lane_valid | output | LANES | Lane k carries an element |
| lane_zero | output | LANES | Lane k writes zero to its destination |
| lane_idx | output | LANES*IW | Element index per lane, lane k at bits [k*IW +: IW] |
| lane_rd | output | LANES*RW | Destination register per lane |
| lane_rs1 | output | LANES*RW | Source 1 register per lane |
| lane_rs2 | output | LANES*RW | Source 2 register per lane |

## Verification
On every cycle, the assertions check a set of per-cycle properties:
- lanes are packed and indices ascend across lanes;
- no lane is valid while the block is ready;
- every lane's register numbers follow the accepted operation's bases and flags;
- a zero flag appears only in zeroing mode on a clear predicate bit;
- no index reaches the captured VL.

Some behaviours span whole operations, and only the directed scenarios can show them:
- every expected element is issued once, with none lost or repeated across cycles;
- the cycle count is ceil(E/LANES);
- all-scalar operations collapse to one element;
- an operation presented while busy is discarded.

// File: rtl/elem_split_pkg.sv
package elem_split_pkg;
  typedef enum logic {
    FILL_SKIP = 1'b0,
    FILL_ZERO = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/elem_pick.sv
module elem_pick #(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int IW    = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]     mask,
  output logic [LANES-1:0]    valid,
  output logic [LANES*IW-1:0] idx,
  output logic [XLEN-1:0]     taken
);
  logic [XLEN-1:0] rem [LANES+1];
  logic [XLEN-1:0] hot [LANES];

  function automatic logic [IW-1:0] encode(input logic [XLEN-1:0] h);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < XLEN; i++)
      if (h[i]) r = r | IW'(i);
    return r;
  endfunction

  assign rem[0] = mask;

  // Each lane peels off the lowest remaining set bit.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign hot[k]             = rem[k] & (~rem[k] + {{(XLEN-1){1'b0}}, 1'b1});
    assign rem[k+1]           = rem[k] & ~hot[k];
    assign valid[k]           = |rem[k];
    assign idx[k*IW +: IW]    = encode(hot[k]);
  end

  assign taken = mask & ~rem[LANES];
endmodule

// File: rtl/elem_regmap.sv
module elem_regmap #(
  parameter int RW = 5,
  parameter int IW = 5
) (
  input  logic [RW-1:0] base,
  input  logic          is_vec,
  input  logic [IW-1:0] elem,
  output logic [RW-1:0] regnum
);
  logic [RW+IW-1:0] sum;

  assign sum    = {{IW{1'b0}}, base} + {{RW{1'b0}}, elem};
  assign regnum = is_vec ? sum[RW-1:0] : base;
endmodule

// File: rtl/elem_issue_split.sv
module elem_issue_split
  import elem_split_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int RW    = 5,
  parameter int IW    = $clog2(XLEN),
  parameter int VW    = $clog2(XLEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [RW-1:0]       op_rd,
  input  logic [RW-1:0]       op_rs1,
  input  logic [RW-1:0]       op_rs2,
  input  logic                op_rd_vec,
  input  logic                op_rs1_vec,
  input  logic                op_rs2_vec,
  input  logic [VW-1:0]       op_vl,
  input  logic [XLEN-1:0]     op_pred,
  input  logic                op_zero,
  output logic [LANES-1:0]    lane_valid,
  output logic [LANES-1:0]    lane_zero,
  output logic [LANES*IW-1:0] lane_idx,
  output logic [LANES*RW-1:0] lane_rd,
  output logic [LANES*RW-1:0] lane_rs1,
  output logic [LANES*RW-1:0] lane_rs2
);
  // Captured operation and pending element set
  logic [XLEN-1:0] pend_q, pend_d;
  logic [XLEN-1:0] pred_q;
  fill_mode_e      fill_q, fill_d;
  logic [RW-1:0]   rd_q, rs1_q, rs2_q;
  logic            rdv_q, rs1v_q, rs2v_q;

  logic            busy, accept, scalar_op;
  logic [XLEN-1:0] len_mask, new_mask, taken;

  assign busy      = |pend_q;
  assign in_ready  = ~busy;
  assign accept    = in_valid & in_ready;
  assign scalar_op = ~(op_rd_vec | op_rs1_vec | op_rs2_vec);

  always_comb begin
    for (int i = 0; i < XLEN; i++)
      len_mask[i] = (VW'(i) < op_vl);
  end

  always_comb begin
    if (scalar_op)
      new_mask = {{(XLEN-1){1'b0}}, 1'b1};
    else if (op_zero)
      new_mask = len_mask;
    else
      new_mask = op_pred & len_mask;
    fill_d = (op_zero && !scalar_op) ? FILL_ZERO : FILL_SKIP;
  end

  // Next pending mask: load on accept, shrink while busy
  always_comb begin
    pend_d = pend_q;
    if (accept)
      pend_d = new_mask;
    else if (busy)
      pend_d = pend_q & ~taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      fill_q <= FILL_SKIP;
      rd_q   <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      rdv_q  <= 1'b0;
      rs1v_q <= 1'b0;
      rs2v_q <= 1'b0;
    end else if (accept) begin
      pred_q <= op_pred;
      fill_q <= fill_d;
      rd_q   <= op_rd;
      rs1_q  <= op_rs1;
      rs2_q  <= op_rs2;
      rdv_q  <= op_rd_vec;
      rs1v_q <= op_rs1_vec;
      rs2v_q <= op_rs2_vec;
    end
  end

  elem_pick #(.XLEN(XLEN), .LANES(LANES), .IW(IW)) u_pick (
    .mask  (pend_q),
    .valid (lane_valid),
    .idx   (lane_idx),
    .taken (taken)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] e;
    assign e            = lane_idx[k*IW +: IW];
    assign lane_zero[k] = lane_valid[k] && (fill_q == FILL_ZERO) && !pred_q[e];

    elem_regmap #(.RW(RW), .IW(IW)) u_rd (
      .base(rd_q), .is_vec(rdv_q), .elem(e), .regnum(lane_rd[k*RW +: RW]));
    elem_regmap #(.RW(RW), .IW(IW)) u_rs1 (
      .base(rs1_q), .is_vec(rs1v_q), .elem(e), .regnum(lane_rs1[k*RW +: RW]));
    elem_regmap #(.RW(RW), .IW(IW)) u_rs2 (
      .base(rs2_q), .is_vec(rs2v_q), .elem(e), .regnum(lane_rs2[k*RW +: RW]));
  end
endmodule

// File: rtl/elem_issue_split_chk.sv
module elem_issue_split_chk #(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int RW    = 5,
  parameter int IW    = $clog2(XLEN),
  parameter int VW    = $clog2(XLEN + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [RW-1:0]       op_rd,
  input logic [RW-1:0]       op_rs1,
  input logic [RW-1:0]       op_rs2,
  input logic                op_rd_vec,
  input logic                op_rs1_vec,
  input logic                op_rs2_vec,
  input logic [VW-1:0]       op_vl,
  input logic [XLEN-1:0]     op_pred,
  input logic                op_zero,
  input logic [LANES-1:0]    lane_valid,
  input logic [LANES-1:0]    lane_zero,
  input logic [LANES*IW-1:0] lane_idx,
  input logic [LANES*RW-1:0] lane_rd,
  input logic [LANES*RW-1:0] lane_rs1,
  input logic [LANES*RW-1:0] lane_rs2
);
  logic [RW-1:0]   c_rd, c_rs1, c_rs2;
  logic            c_rdv, c_rs1v, c_rs2v, c_zero;
  logic [VW-1:0]   c_vl;
  logic [XLEN-1:0] c_pred;
  logic            c_scalar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rd <= '0; c_rs1 <= '0; c_rs2 <= '0;
      c_rdv <= 1'b0; c_rs1v <= 1'b0; c_rs2v <= 1'b0; c_zero <= 1'b0;
      c_vl <= '0; c_pred <= '0;
    end else if (in_valid && in_ready) begin
      c_rd <= op_rd; c_rs1 <= op_rs1; c_rs2 <= op_rs2;
      c_rdv <= op_rd_vec; c_rs1v <= op_rs1_vec; c_rs2v <= op_rs2_vec;
      c_zero <= op_zero; c_vl <= op_vl; c_pred <= op_pred;
    end
  end

  assign c_scalar = ~(c_rdv | c_rs1v | c_rs2v);

  function automatic logic [RW-1:0] want_reg(input logic [RW-1:0] b, input logic v,
                                             input logic [IW-1:0] i);
    logic [RW+IW-1:0] s;
    s = {{IW{1'b0}}, b} + {{RW{1'b0}}, i};
    return v ? s[RW-1:0] : b;
  endfunction

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_valid) |-> !in_ready);

  // R2
  lanes_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid & LANES'(lane_valid + LANES'(1))) == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    logic [IW-1:0] e;
    assign e = lane_idx[k*IW +: IW];

    // R4
    reg_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[k] |-> (lane_rd[k*RW +: RW]  == want_reg(c_rd,  c_rdv,  e)) &&
                        (lane_rs1[k*RW +: RW] == want_reg(c_rs1, c_rs1v, e)) &&
                        (lane_rs2[k*RW +: RW] == want_reg(c_rs2, c_rs2v, e)));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_zero[k] |-> lane_valid[k] && c_zero && !c_scalar && !c_pred[e]);

    // R8
    vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[k] && !c_scalar) |-> (VW'(e) < c_vl));

    if (k > 0) begin : g_ord
      // R2
      ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid[k] |-> (e > lane_idx[(k-1)*IW +: IW]));
    end
  end
endmodule

bind elem_issue_split elem_issue_split_chk #(
  .XLEN(XLEN), .LANES(LANES), .RW(RW), .IW(IW), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2),
  .op_rd_vec(op_rd_vec), .op_rs1_vec(op_rs1_vec), .op_rs2_vec(op_rs2_vec),
  .op_vl(op_vl), .op_pred(op_pred), .op_zero(op_zero),
  .lane_valid(lane_valid), .lane_zero(lane_zero), .lane_idx(lane_idx),
  .lane_rd(lane_rd), .lane_rs1(lane_rs1), .lane_rs2(lane_rs2)
);

// File: tb/test_elem_issue_split.sv
module test_elem_issue_split;
  localparam int XLEN = 32, L = 4, RW = 5, IW = 5, VW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [RW-1:0] op_rd = '0, op_rs1 = '0, op_rs2 = '0;
  logic op_rd_vec = 1'b0, op_rs1_vec = 1'b0, op_rs2_vec = 1'b0, op_zero = 1'b0;
  logic [VW-1:0] op_vl = '0;
  logic [XLEN-1:0] op_pred = '0;
  logic [L-1:0] lane_valid, lane_zero;
  logic [L*IW-1:0] lane_idx;
  logic [L*RW-1:0] lane_rd, lane_rs1, lane_rs2;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  elem_issue_split #(.XLEN(XLEN), .LANES(L), .RW(RW)) i_elem_issue_split (
    .clk, .rst_n, .in_valid, .in_ready, .op_rd, .op_rs1, .op_rs2,
    .op_rd_vec, .op_rs1_vec, .op_rs2_vec, .op_vl, .op_pred, .op_zero,
    .lane_valid, .lane_zero, .lane_idx, .lane_rd, .lane_rs1, .lane_rs2);

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Idle check: no lane valid and ready high
  task automatic chk_idle(string tag);
    chk({tag, " idle"}, {62'd0, lane_valid == '0, in_ready}, 64'd3);
  endtask

  task automatic run_op(string tag, logic [4:0] rd, logic [4:0] r1, logic [4:0] r2,
                        bit dv, bit v1, bit v2, int vl, logic [31:0] pred, bit zm,
                        bit inject);
    logic [21:0] ex [64];
    int n = 0;
    bit scalar = !(dv | v1 | v2);
    if (scalar) begin
      ex[0] = {1'b1, 1'b0, 5'd0, rd, r1, r2};
      n = 1;
    end else begin
      for (int i = 0; i < vl; i++) begin
        if (zm || pred[i]) begin
          ex[n] = {1'b1, zm && !pred[i], 5'(i),
                   dv ? 5'(rd + 5'(i)) : rd, v1 ? 5'(r1 + 5'(i)) : r1,
                   v2 ? 5'(r2 + 5'(i)) : r2};
          n++;
        end
      end
    end
    op_rd = rd; op_rs1 = r1; op_rs2 = r2;
    op_rd_vec = dv; op_rs1_vec = v1; op_rs2_vec = v2;
    op_vl = VW'(vl); op_pred = pred; op_zero = zm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int g = 0; g < (n + L - 1) / L; g++) begin
      for (int k = 0; k < L; k++) begin
        int e = g * L + k;
        logic [21:0] got = {lane_valid[k], lane_zero[k], lane_idx[k*IW +: IW],
                            lane_rd[k*RW +: RW], lane_rs1[k*RW +: RW], lane_rs2[k*RW +: RW]};
        if (e < n) chk($sformatf("%s g%0d lane%0d", tag, g, k), 64'(got), 64'(ex[e]));
        else       chk($sformatf("%s g%0d lane%0d unused", tag, g, k),
                       64'(lane_valid[k]), 64'd0);
      end
      if (inject && g == 0) begin
        // R9: present another operation while busy
        op_rd = rd + 5'd3; op_vl = 6'd2; op_zero = !zm; op_rd_vec = 1'b0;
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk_idle(tag);
    @(negedge clk);
    chk_idle({tag, " after"});
  endtask

  task automatic t_reset;
    chk_idle("R1 reset");
  endtask

  task automatic t_compact;
    run_op("R2 R3 R6 six of eight", 5'd8, 5'd16, 5'd24, 1, 1, 1, 8, 32'h0000_00DB, 0, 0);
  endtask

  task automatic t_regs;
    run_op("R4 wrap mixed", 5'd30, 5'd3, 5'd29, 1, 0, 1, 6, 32'h0000_003F, 0, 0);
  endtask

  task automatic t_scalar;
    run_op("R5 all scalar", 5'd1, 5'd2, 5'd3, 0, 0, 0, 20, 32'h0, 1, 0);
  endtask

  task automatic t_zero;
    run_op("R7 zeroing", 5'd4, 5'd12, 5'd20, 1, 1, 0, 7, 32'h0000_0005, 1, 0);
  endtask

  task automatic t_bounds;
    run_op("R8 vl cuts pred", 5'd0, 5'd10, 5'd20, 1, 1, 1, 3, 32'hFFFF_FFFF, 0, 0);
    run_op("R8 vl zero", 5'd0, 5'd10, 5'd20, 1, 1, 1, 0, 32'hFFFF_FFFF, 1, 0);
    run_op("R8 empty pred", 5'd0, 5'd10, 5'd20, 1, 1, 1, 16, 32'hFFFF_0000, 0, 0);
  endtask

  task automatic t_full;
    run_op("R3 full length", 5'd0, 5'd0, 5'd16, 1, 1, 0, 32, 32'hFFFF_FFFF, 0, 0);
    run_op("R2 sparse", 5'd5, 5'd6, 5'd7, 1, 1, 1, 32, 32'h8001_0420, 0, 0);
  endtask

  task automatic t_busy;
    run_op("R9 busy ignore", 5'd2, 5'd9, 5'd18, 1, 1, 1, 8, 32'h0000_00FF, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compact();
    t_regs();
    t_scalar();
    t_zero();
    t_bounds();
    t_full();
    t_busy();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule